// File: doc/BRIEF.md
# Host Command/Response Mailbox

This block is the register face that a host bus master sees on a data acquisition board. The host reaches it through two adjacent byte addresses, and the low address bit picks between them. Address 0 carries the byte traffic. A host write there deposits a command byte for the local controller, and a host read returns the latest response byte. Address 1 carries the control traffic. A host read there returns a status byte of handshake, alarm and fault flags, and a host write of any value asks for a board reset.

On the local side, the controller sees a command slot with a valid strobe and an acknowledge. It has a load port for response bytes, an alarm input and a fault input. After power-on reset, and after every host-requested board reset, a timer holds the fault flag high for a set number of clock cycles, so the board looks busy while it recovers. The fault flag also drives the fault indicator output. While the flag is up, the other three status flags read as zero.

Top module: `host_mailbox`

## Requirements
- R1: After rst_ni is released, cmd_valid_o and brd_rst_o are low, data-available is clear, the data register holds zero, and the fault flag stays high for exactly FAULT_CYCLES rising clock edges.
- R2: host_rdata_o is combinational. With host_addr_i=0 it shows the data register. With host_addr_i=1 it shows the status byte: bit 7 command-ready, bit 6 data-available, bit 5 alarm, bit 4 fault, bits 3..0 zero. All flags are active-high.
- R3: A host write at address 0 while command-ready reads 1 stores host_wdata_i in cmd_data_o and raises cmd_valid_o on the next cycle. Command-ready then reads 0.
- R4: A host write at address 0 while command-ready reads 0 (a command still pending, or fault active) is ignored, and cmd_data_o keeps its value.
- R5: cmd_ack_i while cmd_valid_o is high drops cmd_valid_o on the next cycle, and command-ready returns.
- R6: rsp_valid_i loads rsp_data_i into the data register and sets data-available on the next cycle. If a host data read arrives in the same cycle, the load wins.
- R7: A host read at address 0 clears data-available on the next cycle. The data register keeps its byte.
- R8: A host write at address 1, whatever its value, drives brd_rst_o high for the next cycle. It also drops any pending command, clears data-available and the data register, and restarts the fault timer. It takes precedence over every other event in that cycle.
- R9: The fault flag is high while the timer runs or fault_i is high. fault_led_o equals the fault flag, and while it is high, status bits 7..5 read 0.
- R10: With the fault flag low, status bit 5 follows alarm_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_addr_i | input | 1 | Low address bit: 0 = command/data, 1 = status/reset |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| brd_rst_o | output | 1 | One-cycle board reset request |
| cmd_valid_o | output | 1 | A command byte is waiting for the local side |
| cmd_data_o | output | 8 | Pending command byte |
| cmd_ack_i | input | 1 | Local side has consumed the command |
| rsp_valid_i | input | 1 | Local side loads a response byte |
| rsp_data_i | input | 8 | Response byte |
| alarm_i | input | 1 | Channel limit exceeded |
| fault_i | input | 1 | Local fault condition |
| fault_led_o | output | 1 | Fault indicator drive |

## Verification
The assertions assume that the host raises at most one of host_wr_i and host_rd_i in a cycle. They also assume that every input is held steady across a clock edge. The bench meets both conditions by driving each input a few nanoseconds after a rising edge, and by choosing each cycle either a write, a read or neither. Acknowledges and response loads arrive at arbitrary times, including while the fault flag is up and in the same cycle as a board reset request, because the block has to give a defined result in those cases as well.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned ST_READY = 7;
  localparam int unsigned ST_DAV   = 6;
  localparam int unsigned ST_ALARM = 5;
  localparam int unsigned ST_FAULT = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t pack_status(input logic ready, input logic dav,
                                        input logic alarm, input logic fault);
    byte_t s;
    s = '0;
    s[ST_READY] = ready & ~fault;
    s[ST_DAV]   = dav & ~fault;
    s[ST_ALARM] = alarm & ~fault;
    s[ST_FAULT] = fault;
    return s;
  endfunction
endpackage

// File: rtl/hm_cmd_slot.sv
module hm_cmd_slot
  import hm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  load_i,
  input  byte_t wdata_i,
  input  logic  ack_i,
  output logic  valid_o,
  output byte_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= wdata_i;
    end else if (ack_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hm_rsp_slot.sv
module hm_rsp_slot
  import hm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  load_i,
  input  byte_t ldata_i,
  input  logic  consume_i,
  output logic  dav_o,
  output byte_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dav_o  <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      dav_o  <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      // load beats a concurrent host read
      dav_o  <= 1'b1;
      data_o <= ldata_i;
    end else if (consume_i) begin
      dav_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/hm_fault_timer.sv
module hm_fault_timer #(
  parameter int unsigned FAULT_CYCLES = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(FAULT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(FAULT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD;
    else if (restart_i)     cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import hm_pkg::*;
#(
  parameter int unsigned FAULT_CYCLES = 50_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic       host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       brd_rst_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_data_o,
  input  logic       cmd_ack_i,
  input  logic       rsp_valid_i,
  input  logic [7:0] rsp_data_i,
  input  logic       alarm_i,
  input  logic       fault_i,
  output logic       fault_led_o
);
  logic  soft_rst, cmd_accept, data_read;
  logic  tmr_busy, fault, dav;
  byte_t rsp_q;
  byte_t status;

  assign fault      = tmr_busy | fault_i;
  assign soft_rst   = host_wr_i & host_addr_i;
  assign cmd_accept = host_wr_i & ~host_addr_i & ~cmd_valid_o & ~fault;
  assign data_read  = host_rd_i & ~host_addr_i;

  hm_cmd_slot u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .load_i  (cmd_accept),
    .wdata_i (host_wdata_i),
    .ack_i   (cmd_ack_i),
    .valid_o (cmd_valid_o),
    .data_o  (cmd_data_o)
  );

  hm_rsp_slot u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (soft_rst),
    .load_i    (rsp_valid_i),
    .ldata_i   (rsp_data_i),
    .consume_i (data_read),
    .dav_o     (dav),
    .data_o    (rsp_q)
  );

  hm_fault_timer #(.FAULT_CYCLES(FAULT_CYCLES)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (soft_rst),
    .busy_o    (tmr_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brd_rst_o <= 1'b0;
    else         brd_rst_o <= soft_rst;
  end

  assign status       = pack_status(~cmd_valid_o, dav, alarm_i, fault);
  assign host_rdata_o = host_addr_i ? status : rsp_q;
  assign fault_led_o  = fault;
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_wr_i,
  input logic       host_addr_i,
  input logic [7:0] host_wdata_i,
  input logic [7:0] host_rdata_o,
  input logic       brd_rst_o,
  input logic       cmd_valid_o,
  input logic [7:0] cmd_data_o,
  input logic       cmd_ack_i,
  input logic       rsp_valid_i,
  input logic [7:0] rsp_data_i,
  input logic       fault_led_o,
  input logic [7:0] status
);
  // R2
  status_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[3:0] == 4'h0);

  // R3
  cmd_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !host_addr_i && status[7]
    |=> cmd_valid_o && cmd_data_o == $past(host_wdata_i));

  // R4
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> $stable(cmd_data_o));

  // R5
  cmd_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ack_i |=> !cmd_valid_o);

  // R6
  rsp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !(host_wr_i && host_addr_i) && !host_addr_i
    |=> host_addr_i || host_rdata_o == $past(rsp_data_i));

  // R8
  brd_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_addr_i |=> brd_rst_o && !cmd_valid_o && fault_led_o);

  // R9
  fault_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_led_o |-> status[7:5] == 3'b000 && status[4]);
endmodule

bind host_mailbox host_mailbox_chk u_chk (.*);

// File: tb/host_mailbox_bench.sv
`timescale 1ns/1ps
module host_mailbox_bench;
  localparam int FC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       brd_rst, cmd_valid, cmd_ack = 1'b0;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic       alarm = 1'b0, fault_in = 1'b0, fault_led;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  host_mailbox #(.FAULT_CYCLES(FC)) u_host_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .brd_rst_o(brd_rst), .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data),
    .cmd_ack_i(cmd_ack), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .alarm_i(alarm), .fault_i(fault_in), .fault_led_o(fault_led)
  );

  // reference model state
  bit m_pend, m_dav, m_brst;
  int m_cmd, m_data, m_cnt;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_fault();
    return (m_cnt != 0) || fault_in;
  endfunction

  function automatic int m_status();
    bit f;
    f = m_fault();
    return ((!m_pend && !f) << 7) | ((m_dav && !f) << 6) |
           ((alarm && !f) << 5) | (f << 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_dav = 0; m_brst = 0; m_cmd = 0; m_data = 0; m_cnt = FC;
    end else begin
      bit f;
      f = m_fault();
      if (host_wr && host_addr) begin
        m_pend = 0; m_dav = 0; m_data = 0; m_cnt = FC; m_brst = 1;
      end else begin
        m_brst = 0;
        if (m_cnt > 0) m_cnt--;
        if (host_wr && !host_addr && !m_pend && !f) begin
          m_pend = 1; m_cmd = host_wdata;
        end else if (m_pend && cmd_ack) m_pend = 0;
        if (rsp_valid) begin
          m_data = rsp_data; m_dav = 1;
        end else if (host_rd && !host_addr) m_dav = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 cmd_valid", cmd_valid, m_pend);
      chk("R4 cmd_data", cmd_data, m_cmd);
      chk("R8 brd_rst", brd_rst, m_brst);
      chk("R9 fault_led", fault_led, m_fault());
      if (host_addr) chk("R2 status", host_rdata, m_status());
      else           chk("R6 data", host_rdata, m_data);
    end
  end

  task automatic idle();
    host_wr = 0; host_rd = 0; cmd_ack = 0; rsp_valid = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    // watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    step(0);
    @(negedge clk);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 brd_rst", brd_rst, 0);
    host_addr = 1;
    #1 chk("R1 fault status", host_rdata, 8'h10);
    // fault must last FC edges after release
    step(FC - 2);
    @(negedge clk);
    chk("R1 fault still on", fault_led, 1);
    step(0); @(negedge clk);
    chk("R1 fault off", fault_led, 0);
    chk("R2 idle status", host_rdata, 8'h80);
    step(0);
    alarm = 1;
    @(negedge clk);
    chk("R10 alarm bit", host_rdata, 8'hA0);
    step(0); alarm = 0;

    // command write and ack
    host_addr = 0; host_wr = 1; host_wdata = 8'h5A;
    step(1); idle();
    @(negedge clk);
    chk("R3 cmd_valid", cmd_valid, 1);
    chk("R3 cmd_data", cmd_data, 8'h5A);
    step(0); host_wr = 1; host_wdata = 8'hC3;
    step(1); idle();
    @(negedge clk);
    chk("R4 ignored", cmd_data, 8'h5A);
    step(0); cmd_ack = 1;
    step(1); idle();
    host_addr = 1;
    @(negedge clk);
    chk("R5 ready back", host_rdata, 8'h80);

    // response path
    step(0); rsp_valid = 1; rsp_data = 8'h3C;
    step(1); idle();
    @(negedge clk);
    chk("R6 dav set", host_rdata, 8'hC0);
    step(0); host_addr = 0; host_rd = 1; rsp_valid = 1; rsp_data = 8'h77;
    step(1); idle();
    @(negedge clk);
    chk("R6 load wins", host_rdata, 8'h77);
    step(0); host_rd = 1;
    step(1); idle(); host_addr = 1;
    @(negedge clk);
    chk("R7 dav clear", host_rdata, 8'h80);
    host_addr = 0;
    #1 chk("R7 data kept", host_rdata, 8'h77);

    // board reset with pending command
    step(0); host_wr = 1; host_wdata = 8'h11;
    step(1); host_addr = 1; host_wdata = 8'hFF;
    step(1); idle();
    @(negedge clk);
    chk("R8 pulse", brd_rst, 1);
    chk("R8 cmd dropped", cmd_valid, 0);
    chk("R8 fault restart", fault_led, 1);
    step(1); @(negedge clk);
    chk("R8 pulse end", brd_rst, 0);
    step(FC);

    // local fault masks flags, blocks commands
    fault_in = 1; alarm = 1;
    @(negedge clk);
    chk("R9 mask", host_rdata, 8'h10);
    step(0); host_addr = 0; host_wr = 1; host_wdata = 8'h99;
    step(1); idle();
    @(negedge clk);
    chk("R4 fault blocks", cmd_valid, 0);
    step(0); fault_in = 0; alarm = 0;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      host_wr = 0; host_rd = 0;
      host_addr = $urandom_range(0, 1);
      if (op == 0 && $urandom_range(0, 7) == 0) host_wr = 1;
      else if (op >= 1 && op <= 3) begin host_wr = 1; host_addr = 0; end
      else if (op >= 4 && op <= 6) host_rd = 1;
      host_wdata = 8'($urandom);
      cmd_ack = ($urandom_range(0, 2) == 0);
      rsp_valid = ($urandom_range(0, 3) == 0);
      rsp_data = 8'($urandom);
      alarm = $urandom_range(0, 1);
      fault_in = ($urandom_range(0, 15) == 0);
      step(1);
    end
    idle();
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule